// File: doc/BRIEF.md
# LVDS Lane Bit Mux Serializer

This block turns one parallel pixel word per pixel period into 7-bit serial frames on up to two channels of LVDS data lanes. Every serial slot of every data lane takes its bit from the pixel word through a programmable 5-bit index. Two index tables are held in the block, one for 24-bit colour and one for 18-bit colour. Both tables are loaded with working defaults at reset and can be rewritten one entry at a time through a small write port. A clock lane per channel carries a fixed 7-slot pattern that marks the frame boundary.

The fast serial rate is modelled as a clock enable, `fast_en`, on the system clock. Each enable shifts out one slot per lane. The colour depth, the single- or dual-channel selection and the channel swap are sampled while serialization is off. They are frozen once `ser_en` goes high, so software applies the configuration first and then raises the enable. While `ser_en` is low every lane stays at 0.

Top module: `lvds_lane_serializer`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, all lane outputs and `rgb_out` are 0. The configuration resets to 24-bit, single channel, no swap, and both index tables return to their defaults (R11).
- R2: While `ser_en` is low, every data and clock lane output reads 0 one clock later and the slot position returns to 0. The configuration inputs are captured on every clock while `ser_en` is low and are ignored while it is high.
- R3: While `ser_en` is high, each clock with `fast_en` high emits the next slot on every lane, registered, in the order 0,1,…,6 and then back to 0. `pix_word` is captured on the enable that emits slot 0, and slots 1–6 use that captured word. Outputs hold between enables.
- R4: The bit for lane L and slot S is `pix_word[idx]`, where `idx` is the table entry for the active depth, L and S. An index of 28 to 31 yields 0.
- R5: In 24-bit mode data lanes 0–3 are active. In 18-bit mode lanes 0–2 are active and lane 3 drives 0.
- R6: In single-channel mode channel 2's data and clock lanes drive 0. In dual-channel mode channel 2 carries the same data bits as channel 1 and its own clock lane.
- R7: An active clock lane outputs 1,1,0,0,0,1,1 for slots 0 to 6.
- R8: With swap set, the complete channel 1 and channel 2 outputs (data and clock) are exchanged.
- R9: `rgb_out` is 1 exactly when the held configuration is 18-bit.
- R10: A write with `map_we` high stores `map_idx` into table `map_sel24` (1 = 24-bit), lane `map_lane`, slot `map_slot`. The new value is used from the next clock; a slot emitted on the same edge still uses the old value. A write with `map_slot` = 7 is dropped.
- R11: The default indices for slots 0..6 are as follows. 24-bit: lane0 8,5,4,3,2,1,0; lane1 17,16,13,12,11,10,9; lane2 26,25,24,21,20,19,18; lane3 27,23,22,15,14,7,6. 18-bit: lane0 10,7,6,5,4,3,2; lane1 19,18,15,14,13,12,11; lane2 26,25,24,23,22,21,20; lane3 all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_en | input | 1 | Serial slot enable (7 per pixel) |
| pix_word | input | 28 | Parallel pixel source word |
| depth24 | input | 1 | 1 = 24-bit colour, 0 = 18-bit |
| dual_ch | input | 1 | 1 = both channels active |
| swap_ch | input | 1 | Exchange channel 1 and channel 2 outputs |
| ser_en | input | 1 | Serialization enable |
| map_we | input | 1 | Index table write strobe |
| map_sel24 | input | 1 | Table select for write (1 = 24-bit) |
| map_lane | input | 2 | Lane of table entry |
| map_slot | input | 3 | Slot of table entry |
| map_idx | input | 5 | Source bit index to store |
| ch1_data | output | 4 | Channel 1 data lanes |
| ch1_clk | output | 1 | Channel 1 clock lane |
| ch2_data | output | 4 | Channel 2 data lanes |
| ch2_clk | output | 1 | Channel 2 clock lane |
| rgb_out | output | 1 | High in 18-bit mode |

## Verification
Two events can share one clock edge. A table write may land on the same edge that emits a slot reading that very entry. A change to the configuration inputs may arrive on the edge where `ser_en` rises. The bench provokes the first by streaming random writes to the active table while slots are being emitted, so some writes hit the current slot. The model applies each write only after computing that edge's outputs. The second is provoked by changing depth, lane count and swap during serialization and across enable edges. The bench judges it by requiring the outputs and `rgb_out` to follow only the configuration captured while the enable was low.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  localparam int PIX_W = 28;
  localparam int IDX_W = 5;
  localparam int SLOTS = 7;
  localparam int LANES = 4;

  // Reset-time source index for (mode, lane, slot); mode 1 = 24-bit.
  function automatic logic [IDX_W-1:0] default_idx(input int mode, input int lane, input int slot);
    logic [SLOTS*IDX_W-1:0] row;
    case (mode * 4 + lane)
      4:       row = {5'd8,  5'd5,  5'd4,  5'd3,  5'd2,  5'd1,  5'd0};
      5:       row = {5'd17, 5'd16, 5'd13, 5'd12, 5'd11, 5'd10, 5'd9};
      6:       row = {5'd26, 5'd25, 5'd24, 5'd21, 5'd20, 5'd19, 5'd18};
      7:       row = {5'd27, 5'd23, 5'd22, 5'd15, 5'd14, 5'd7,  5'd6};
      0:       row = {5'd10, 5'd7,  5'd6,  5'd5,  5'd4,  5'd3,  5'd2};
      1:       row = {5'd19, 5'd18, 5'd15, 5'd14, 5'd13, 5'd12, 5'd11};
      2:       row = {5'd26, 5'd25, 5'd24, 5'd23, 5'd22, 5'd21, 5'd20};
      default: row = '0;
    endcase
    return row[(SLOTS-1-slot)*IDX_W +: IDX_W];
  endfunction
endpackage

// File: rtl/lane_map_store.sv
module lane_map_store
  import lvds_ser_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int N_SLOTS = SLOTS,
  parameter int IW      = IDX_W,
  localparam int LANE_W = $clog2(N_LANES),
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic                  wsel,
  input  logic [LANE_W-1:0]     wlane,
  input  logic [SLOT_W-1:0]     wslot,
  input  logic [IW-1:0]         widx,
  input  logic                  rsel,
  input  logic [SLOT_W-1:0]     rslot,
  output logic [N_LANES*IW-1:0] ridx
);
  logic [IW-1:0] tab [2][N_LANES][N_SLOTS];

  for (genvar m = 0; m < 2; m++) begin : g_mode
    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
      for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
          if (rst)
            tab[m][l][s] <= default_idx(m, l, s);
          else if (we && wsel == m[0] && wlane == LANE_W'(l) && wslot == SLOT_W'(s))
            tab[m][l][s] <= widx;
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < N_LANES; l++)
      ridx[l*IW +: IW] = tab[rsel][l][rslot];
  end
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import lvds_ser_pkg::*;
#(
  parameter int N_SLOTS = SLOTS,
  parameter int PW      = PIX_W,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              step,
  input  logic [PW-1:0]     pix_in,
  output logic [SLOT_W-1:0] slot,
  output logic [PW-1:0]     word
);
  logic [PW-1:0] pix_q;
  logic          first;

  assign first = (slot == '0);
  assign word  = first ? pix_in : pix_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      slot <= '0;
    end else if (step) begin
      slot <= (slot == SLOT_W'(N_SLOTS-1)) ? '0 : slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pix_q <= '0;
    else if (run && step && first)
      pix_q <= pix_in;
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst) slot < SLOT_W'(N_SLOTS)); // R3
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && step && slot == SLOT_W'(N_SLOTS-1)) |=> (slot == '0)); // R3
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && !step) |=> $stable(slot)); // R3
endmodule

// File: rtl/lane_router.sv
module lane_router
  import lvds_ser_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int N_SLOTS = SLOTS,
  parameter int PW      = PIX_W,
  parameter int IW      = IDX_W,
  parameter logic [N_SLOTS-1:0] CLK_PAT = 7'b1100011,
  localparam int SLOT_W = $clog2(N_SLOTS),
  localparam int WIDE   = 2**IW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  step,
  input  logic [PW-1:0]         word,
  input  logic [N_LANES*IW-1:0] ridx,
  input  logic [SLOT_W-1:0]     slot,
  input  logic                  depth24,
  input  logic                  dual,
  input  logic                  swap,
  output logic [N_LANES-1:0]    ch1_data,
  output logic                  ch1_clk,
  output logic [N_LANES-1:0]    ch2_data,
  output logic                  ch2_clk
);
  logic [WIDE-1:0]    wide;
  logic [N_LANES-1:0] lane_bit, pri_d, sec_d;
  logic               clk_bit, pri_c, sec_c;

  assign wide = {{(WIDE-PW){1'b0}}, word};

  for (genvar l = 0; l < N_LANES; l++) begin : g_pick
    logic [IW-1:0] idx;
    logic          live;
    assign idx         = ridx[l*IW +: IW];
    assign live        = (l < N_LANES-1) || depth24;
    assign lane_bit[l] = live && (idx < IW'(PW)) && wide[idx];
  end

  assign clk_bit = CLK_PAT[slot];
  assign pri_d   = lane_bit;
  assign pri_c   = clk_bit;
  assign sec_d   = dual ? lane_bit : '0;
  assign sec_c   = dual & clk_bit;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ch1_data <= '0;
      ch1_clk  <= 1'b0;
      ch2_data <= '0;
      ch2_clk  <= 1'b0;
    end else if (step) begin
      ch1_data <= swap ? sec_d : pri_d;
      ch1_clk  <= swap ? sec_c : pri_c;
      ch2_data <= swap ? pri_d : sec_d;
      ch2_clk  <= swap ? pri_c : sec_c;
    end
  end

  AST_TOP_LANE_OFF: assert property (@(posedge clk) disable iff (rst)
    !depth24 |-> (!ch1_data[N_LANES-1] && !ch2_data[N_LANES-1])); // R5
  AST_SINGLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !dual |-> (swap ? (ch1_data == '0 && !ch1_clk) : (ch2_data == '0 && !ch2_clk))); // R6
endmodule

// File: rtl/lvds_lane_serializer.sv
module lvds_lane_serializer
  import lvds_ser_pkg::*;
#(
  parameter int PW      = PIX_W,
  parameter int IW      = IDX_W,
  parameter int N_SLOTS = SLOTS,
  parameter int N_LANES = LANES,
  localparam int LANE_W = $clog2(N_LANES),
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fast_en,
  input  logic [PW-1:0]      pix_word,
  input  logic               depth24,
  input  logic               dual_ch,
  input  logic               swap_ch,
  input  logic               ser_en,
  input  logic               map_we,
  input  logic               map_sel24,
  input  logic [LANE_W-1:0]  map_lane,
  input  logic [SLOT_W-1:0]  map_slot,
  input  logic [IW-1:0]      map_idx,
  output logic [N_LANES-1:0] ch1_data,
  output logic               ch1_clk,
  output logic [N_LANES-1:0] ch2_data,
  output logic               ch2_clk,
  output logic               rgb_out
);
  logic                  cfg_d24, cfg_dual, cfg_swap;
  logic [SLOT_W-1:0]     slot;
  logic [PW-1:0]         word;
  logic [N_LANES*IW-1:0] ridx;

  // Configuration follows the inputs only while serialization is off.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_d24  <= 1'b1;
      cfg_dual <= 1'b0;
      cfg_swap <= 1'b0;
    end else if (!ser_en) begin
      cfg_d24  <= depth24;
      cfg_dual <= dual_ch;
      cfg_swap <= swap_ch;
    end
  end

  assign rgb_out = ~cfg_d24;

  lane_map_store #(.N_LANES(N_LANES), .N_SLOTS(N_SLOTS), .IW(IW)) u_store (
    .clk(clk), .rst(rst), .we(map_we), .wsel(map_sel24), .wlane(map_lane),
    .wslot(map_slot), .widx(map_idx), .rsel(cfg_d24), .rslot(slot), .ridx(ridx)
  );

  slot_sequencer #(.N_SLOTS(N_SLOTS), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .run(ser_en), .step(fast_en), .pix_in(pix_word),
    .slot(slot), .word(word)
  );

  lane_router #(.N_LANES(N_LANES), .N_SLOTS(N_SLOTS), .PW(PW), .IW(IW)) u_route (
    .clk(clk), .rst(rst), .run(ser_en), .step(fast_en), .word(word), .ridx(ridx),
    .slot(slot), .depth24(cfg_d24), .dual(cfg_dual), .swap(cfg_swap),
    .ch1_data(ch1_data), .ch1_clk(ch1_clk), .ch2_data(ch2_data), .ch2_clk(ch2_clk)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ser_en |=> (ch1_data == '0 && ch2_data == '0 && !ch1_clk && !ch2_clk)); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    $past(ser_en) |-> $stable({cfg_d24, cfg_dual, cfg_swap})); // R2
  AST_RGB_MODE: assert property (@(posedge clk) disable iff (rst)
    rgb_out |-> !ch1_data[N_LANES-1]); // R9
endmodule

// File: tb/tb_lvds_lane_serializer.sv
module tb_lvds_lane_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fast_en = 1'b0;
  logic [27:0] pix_word = '0;
  logic        depth24 = 1'b1, dual_ch = 1'b0, swap_ch = 1'b0, ser_en = 1'b0;
  logic        map_we = 1'b0, map_sel24 = 1'b0;
  logic [1:0]  map_lane = '0;
  logic [2:0]  map_slot = '0;
  logic [4:0]  map_idx = '0;
  logic [3:0]  ch1_data, ch2_data;
  logic        ch1_clk, ch2_clk, rgb_out;

  int errors = 0, checks = 0, cycles = 0;

  lvds_lane_serializer dut (
    .clk(clk), .rst(rst), .fast_en(fast_en), .pix_word(pix_word), .depth24(depth24),
    .dual_ch(dual_ch), .swap_ch(swap_ch), .ser_en(ser_en), .map_we(map_we),
    .map_sel24(map_sel24), .map_lane(map_lane), .map_slot(map_slot), .map_idx(map_idx),
    .ch1_data(ch1_data), .ch1_clk(ch1_clk), .ch2_data(ch2_data), .ch2_clk(ch2_clk),
    .rgb_out(rgb_out)
  );

  always #4 clk = ~clk;  // 125 MHz

  // R11 default tables, slot 0 first
  function automatic int dflt(int m, int l, int s);
    int t24 [4][7] = '{'{8,5,4,3,2,1,0}, '{17,16,13,12,11,10,9},
                       '{26,25,24,21,20,19,18}, '{27,23,22,15,14,7,6}};
    int t18 [4][7] = '{'{10,7,6,5,4,3,2}, '{19,18,15,14,13,12,11},
                       '{26,25,24,23,22,21,20}, '{0,0,0,0,0,0,0}};
    return m ? t24[l][s] : t18[l][s];
  endfunction

  // Reference model
  int          tab [2][4][7];
  int          m_slot;
  logic [27:0] m_pix;
  logic        m_d24, m_dual, m_swap;
  logic [3:0]  e1d, e2d;
  logic        e1c, e2c, ergb;

  always @(posedge clk) begin
    logic [27:0] w;
    logic [3:0]  bits;
    logic        cb;
    int          ix;
    if (rst) begin
      for (int m = 0; m < 2; m++)
        for (int l = 0; l < 4; l++)
          for (int s = 0; s < 7; s++) tab[m][l][s] = dflt(m, l, s);
      m_slot = 0; m_pix = '0; m_d24 = 1; m_dual = 0; m_swap = 0;
      e1d = '0; e2d = '0; e1c = 0; e2c = 0;
    end else begin
      if (!ser_en) begin
        m_d24 = depth24; m_dual = dual_ch; m_swap = swap_ch;
        m_slot = 0; e1d = '0; e2d = '0; e1c = 0; e2c = 0;
      end else if (fast_en) begin
        w = (m_slot == 0) ? pix_word : m_pix;
        if (m_slot == 0) m_pix = pix_word;
        for (int l = 0; l < 4; l++) begin
          ix = tab[m_d24 ? 1 : 0][l][m_slot];
          bits[l] = (ix < 28) ? w[ix] : 1'b0;
          if (l == 3 && !m_d24) bits[l] = 1'b0;
        end
        cb = (m_slot <= 1) || (m_slot >= 5);
        if (m_swap) begin
          e1d = m_dual ? bits : '0; e1c = m_dual & cb; e2d = bits; e2c = cb;
        end else begin
          e1d = bits; e1c = cb; e2d = m_dual ? bits : '0; e2c = m_dual & cb;
        end
        m_slot = (m_slot + 1) % 7;
      end
      if (map_we && map_slot < 7) tab[map_sel24 ? 1 : 0][map_lane][map_slot] = map_idx;
    end
    ergb = !m_d24;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Compared on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(ch1_data == e1d, "R4 ch1_data", ch1_data, e1d);
      chk(ch2_data == e2d, "R6 ch2_data", ch2_data, e2d);
      chk(ch1_clk == e1c, "R7 ch1_clk", ch1_clk, e1c);
      chk(ch2_clk == e2c, "R8 ch2_clk", ch2_clk, e2c);
      chk(rgb_out == ergb, "R9 rgb_out", rgb_out, ergb);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_cycles(input int n, input int fe_mod, input bit rnd_pix, input bit rnd_map);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      fast_en = (fe_mod <= 1) ? 1'b1 : ($urandom % fe_mod == 0);
      if (rnd_pix) pix_word = 28'($urandom);
      map_we = rnd_map && ($urandom % 3 == 0);
      map_sel24 = 1'($urandom); map_lane = 2'($urandom);
      map_slot = 3'($urandom); map_idx = 5'($urandom);
    end
    @(negedge clk); #1; map_we = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state visible while reset is held
    chk(ch1_data == 0 && ch2_data == 0 && !ch1_clk && !ch2_clk, "R1 outputs", ch1_data, 0);
    chk(rgb_out == 0, "R1 rgb_out", rgb_out, 0);
    #1 rst = 0;
    @(negedge clk); #1;
    // R11: lane 0 slot 0 of the 24-bit default reads bit 8
    pix_word = 28'h0000100; fast_en = 1; ser_en = 1;
    @(negedge clk);
    chk(ch1_data == 4'b0001 && ch1_clk, "R11 first slot", ch1_data, 1);
    // R3 R4 R5 R7: 24-bit single channel, every cycle and sparse enables
    run_cycles(40, 1, 1, 0);
    run_cycles(60, 3, 1, 0);
    // R2: idle, then 18-bit dual channel (R5 R6 R9)
    ser_en = 0; depth24 = 0; dual_ch = 1;
    run_cycles(3, 1, 1, 0);
    chk(ch1_data == 0 && ch2_data == 0, "R2 idle lanes", ch1_data, 0);
    ser_en = 1;
    run_cycles(60, 2, 1, 0);
    // R8: swap with single channel, then dual
    ser_en = 0; swap_ch = 1; dual_ch = 0; depth24 = 1;
    run_cycles(2, 1, 1, 0);
    ser_en = 1;
    run_cycles(40, 1, 1, 0);
    // R2: configuration changes while running are ignored
    depth24 = 0; dual_ch = 1; swap_ch = 0;
    run_cycles(30, 2, 1, 0);
    ser_en = 0;
    run_cycles(2, 1, 1, 0);
    ser_en = 1;
    // R10 R4: table writes during serialization, including slot 7 and indices >= 28
    run_cycles(300, 2, 1, 1);
    depth24 = 1;
    for (int k = 0; k < 20; k++) begin
      ser_en = 0;
      dual_ch = 1'($urandom); swap_ch = 1'($urandom); depth24 = 1'($urandom);
      run_cycles(1 + $urandom % 3, 1, 1, 1);
      ser_en = 1;
      run_cycles(20 + $urandom % 20, 2, 1, 1);
    end
    // R1: reset restores the defaults after rewrites
    rst = 1; ser_en = 0; depth24 = 1; dual_ch = 1; swap_ch = 0;
    repeat (2) @(negedge clk);
    #1 rst = 0;
    @(negedge clk); #1; ser_en = 1; pix_word = 28'h8000000; fast_en = 1;
    @(negedge clk);
    // R11: lane 3 slot 0 of the 24-bit default reads bit 27
    chk(ch1_data == 4'b1000 && ch2_data == 4'b1000, "R11 lane3 default", ch1_data, 8);
    run_cycles(40, 1, 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule